// File: doc/BRIEF.md
# Dual Receive Message Queue Controller

This block holds received messages for a CAN-style controller in two independent receive queues. When the receive path reports a message that was received without error and passed the acceptance filters, the block stores it. The stored element holds the frame payload, the capture timestamp and the index of the filter that matched. A queue-select input picks which of the two queues the message goes to. Each queue tracks a write index, a read index and a fill level.

The host drains a queue with a fixed loop. It reads the element presented at the queue's read index. It then issues a register write with that queue's increment-read-index bit set, which frees the slot. It repeats until the fill level is zero. A receive into a full queue is discarded and raises a sticky overflow flag, which the host clears by writing 1. A per-queue threshold drives a level interrupt request while the fill level is above the threshold.

Top module: `rxq_pair_ctrl`

## Requirements
- R1: After synchronous reset, both fill levels, both read indices, both overflow flags and both interrupt requests are zero.
- R2: A cycle with `rx_valid` and `rx_ok` high, into a queue that is not full, raises that queue's fill level by one at the next clock edge. The other queue is unchanged. `rx_sel` = 0 selects queue 0 and `rx_sel` = 1 selects queue 1.
- R3: When `rx_valid` is high and `rx_ok` is low, nothing is stored and no fill level, index or flag changes.
- R4: With `host_rd_sel` = q, the element outputs show the payload, timestamp and filter index of the oldest message held in queue q. Messages come out in arrival order.
- R5: A cycle with `host_wr` high and `host_iri[q]` = 1, while queue q is not empty, advances that queue's read index by one and lowers its fill level by one.
- R6: An increment-read-index request on an empty queue changes neither its read index nor its fill level.
- R7: When an accepted receive and an increment-read-index request hit the same non-empty, non-full queue in one cycle, the fill level stays the same and both indices advance.
- R8: An accepted receive into a queue holding 32 elements is discarded, even if a read-index increment hits that queue in the same cycle. The contents and fill level are unchanged by it, and the queue's overflow flag is set from the next cycle.
- R9: The overflow flag stays set until a cycle with `host_wr` high and `host_ovf_clr[q]` = 1 clears it. A new overflow in that same cycle keeps it set.
- R10: `q_wm_irq[q]` is high exactly while queue q's fill level is greater than `wm_thr[q]`.
- R11: Read and write indices run from 0 to 31 and wrap to 0 after 31.
- R12: `host_iri` and `host_ovf_clr` have no effect in cycles where `host_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive path presents a finished message this cycle |
| rx_ok | input | 1 | Message was error-free and passed filtering |
| rx_sel | input | 1 | Target queue (0 or 1) |
| rx_data | input | 64 | Message payload word |
| rx_ts | input | 16 | Capture timestamp |
| rx_fidx | input | 5 | Index of the matching filter |
| host_wr | input | 1 | Host register write strobe |
| host_iri | input | 2 | Per-queue increment-read-index bits of the write |
| host_ovf_clr | input | 2 | Per-queue overflow write-1-to-clear bits |
| wm_thr | input | 2x6 | Per-queue interrupt threshold |
| host_rd_sel | input | 1 | Queue whose head element is presented |
| q_rd_idx | output | 2x5 | Per-queue read index |
| q_fill | output | 2x6 | Per-queue fill level (0 to 32) |
| q_ovf | output | 2 | Per-queue sticky overflow flag |
| q_wm_irq | output | 2 | Per-queue threshold interrupt request |
| elem_data | output | 64 | Payload of the selected queue's head element |
| elem_ts | output | 16 | Timestamp of the head element |
| elem_fidx | output | 5 | Filter index of the head element |

## Verification
A message arrival and a host slot release can land on the same queue in the same clock cycle. The bench forces this with directed cycles on a partly filled queue, where the fill level must hold while both indices step. It repeats the case on a full queue, where the arrival must be dropped and the flag must be set while the release still goes through. Random phases then draw arrival and release independently for each cycle and queue, so the overlap recurs at many fill levels. Every result is judged against a reference queue model kept in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int NQ = 2;

    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } q_op_t;

    function automatic q_op_t decode_op(input logic hit, input logic iri,
                                        input logic empty, input logic full);
        q_op_t op;
        op.push = hit & ~full;
        op.pop  = iri & ~empty;
        op.drop = hit & full;
        return op;
    endfunction

    function automatic int next_idx(input int idx, input int depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 32,
    parameter int ELEM_W = 85,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [ELEM_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [ELEM_W-1:0] rdata
);
    logic [ELEM_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_queue.sv
module rxq_queue import rxq_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_hit,
    input  logic             iri_req,
    input  logic             ovf_clr,
    input  logic [CNT_W-1:0] wm_thr,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] fill,
    output logic             ovf,
    output logic             wm_irq,
    output logic             push
);
    q_op_t op;
    logic  empty;
    logic  full;

    assign empty  = (fill == '0);
    assign full   = (fill == CNT_W'(DEPTH));
    assign op     = decode_op(rx_hit, iri_req, empty, full);
    assign push   = op.push;
    assign wm_irq = (fill > wm_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            fill   <= '0;
            ovf    <= 1'b0;
        end else begin
            if (op.push) wr_idx <= IDX_W'(next_idx(int'(wr_idx), DEPTH));
            if (op.pop)  rd_idx <= IDX_W'(next_idx(int'(rd_idx), DEPTH));
            case ({op.push, op.pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
            if (op.drop)       ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R2
    push_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_hit && !iri_req && fill < CNT_W'(DEPTH)) |=> (fill == $past(fill) + 1'b1));

    // R6
    empty_iri_chk: assert property (@(posedge clk) disable iff (rst)
        (iri_req && !rx_hit && fill == '0) |=> (fill == '0 && rd_idx == $past(rd_idx)));

    // R7
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_hit && iri_req && fill != '0 && fill != CNT_W'(DEPTH))
        |=> (fill == $past(fill) && rd_idx != $past(rd_idx) && wr_idx != $past(wr_idx)));

    // R8
    drop_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_hit && fill == CNT_W'(DEPTH)) |=> (ovf && wr_idx == $past(wr_idx)));

    // R11
    idx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((int'(wr_idx) - int'(rd_idx) + DEPTH) % DEPTH) == (int'(fill) % DEPTH));
endmodule

// File: rtl/rxq_pair_ctrl.sv
module rxq_pair_ctrl import rxq_pkg::*; #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 64,
    parameter int TS_W   = 16,
    parameter int FIDX_W = 5,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = IDX_W + 1,
    localparam int ELEM_W = DATA_W + TS_W + FIDX_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic                       rx_ok,
    input  logic                       rx_sel,
    input  logic [DATA_W-1:0]          rx_data,
    input  logic [TS_W-1:0]            rx_ts,
    input  logic [FIDX_W-1:0]          rx_fidx,
    input  logic                       host_wr,
    input  logic [NQ-1:0]              host_iri,
    input  logic [NQ-1:0]              host_ovf_clr,
    input  logic [NQ-1:0][CNT_W-1:0]   wm_thr,
    input  logic                       host_rd_sel,
    output logic [NQ-1:0][IDX_W-1:0]   q_rd_idx,
    output logic [NQ-1:0][CNT_W-1:0]   q_fill,
    output logic [NQ-1:0]              q_ovf,
    output logic [NQ-1:0]              q_wm_irq,
    output logic [DATA_W-1:0]          elem_data,
    output logic [TS_W-1:0]            elem_ts,
    output logic [FIDX_W-1:0]          elem_fidx
);
    logic [ELEM_W-1:0] wr_elem;
    logic [ELEM_W-1:0] rd_elem [NQ];

    assign wr_elem = {rx_data, rx_ts, rx_fidx};

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic             hit;
        logic             push;
        logic [IDX_W-1:0] wr_idx;

        assign hit = rx_valid & rx_ok & (rx_sel == 1'(q));

        rxq_queue #(.DEPTH(DEPTH)) u_queue (
            .clk     (clk),
            .rst     (rst),
            .rx_hit  (hit),
            .iri_req (host_wr & host_iri[q]),
            .ovf_clr (host_wr & host_ovf_clr[q]),
            .wm_thr  (wm_thr[q]),
            .wr_idx  (wr_idx),
            .rd_idx  (q_rd_idx[q]),
            .fill    (q_fill[q]),
            .ovf     (q_ovf[q]),
            .wm_irq  (q_wm_irq[q]),
            .push    (push)
        );

        rxq_store #(.DEPTH(DEPTH), .ELEM_W(ELEM_W)) u_store (
            .clk   (clk),
            .we    (push),
            .waddr (wr_idx),
            .wdata (wr_elem),
            .raddr (q_rd_idx[q]),
            .rdata (rd_elem[q])
        );
    end

    assign {elem_data, elem_ts, elem_fidx} = rd_elem[host_rd_sel];

    // R3
    rejected_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ok && !host_wr) |=> (q_fill == $past(q_fill) && q_ovf == $past(q_ovf)));

    // R12
    no_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_wr && !rx_valid) |=> (q_rd_idx == $past(q_rd_idx) && q_ovf == $past(q_ovf)));
endmodule

// File: tb/rxq_pair_ctrl_bench.sv
module rxq_pair_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst;
    logic rx_valid, rx_ok, rx_sel;
    logic [63:0] rx_data;
    logic [15:0] rx_ts;
    logic [4:0]  rx_fidx;
    logic host_wr;
    logic [1:0] host_iri, host_ovf_clr;
    logic [1:0][5:0] wm_thr;
    logic host_rd_sel;
    logic [1:0][4:0] q_rd_idx;
    logic [1:0][5:0] q_fill;
    logic [1:0] q_ovf, q_wm_irq;
    logic [63:0] elem_data;
    logic [15:0] elem_ts;
    logic [4:0]  elem_fidx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int mfill [2];
    int mrd   [2];
    int mwr   [2];
    bit movf  [2];
    logic [84:0] mmem [2][DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_pair_ctrl u_rxq_pair_ctrl (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ok(rx_ok), .rx_sel(rx_sel),
        .rx_data(rx_data), .rx_ts(rx_ts), .rx_fidx(rx_fidx), .host_wr(host_wr),
        .host_iri(host_iri), .host_ovf_clr(host_ovf_clr), .wm_thr(wm_thr),
        .host_rd_sel(host_rd_sel), .q_rd_idx(q_rd_idx), .q_fill(q_fill),
        .q_ovf(q_ovf), .q_wm_irq(q_wm_irq), .elem_data(elem_data),
        .elem_ts(elem_ts), .elem_fidx(elem_fidx)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired got %0d cycles exp < 150000", cyc);
                summary();
            end
        end
    end

    task automatic cmp(string tag, string what, int q, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s q%0d %s got %0h exp %0h", tag, q, what, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int q = 0; q < 2; q++) begin
            mfill[q] = 0; mrd[q] = 0; mwr[q] = 0; movf[q] = 0;
        end
    endfunction

    function automatic void model_clock();
        for (int q = 0; q < 2; q++) begin
            bit hit, pop, full;
            hit  = rx_valid && rx_ok && (int'(rx_sel) == q);
            pop  = host_wr && host_iri[q] && mfill[q] > 0;
            full = (mfill[q] == DEPTH);
            if (hit && !full) begin
                mmem[q][mwr[q]] = {rx_data, rx_ts, rx_fidx};
                mwr[q] = (mwr[q] + 1) % DEPTH;
                mfill[q]++;
            end
            if (pop) begin
                mrd[q] = (mrd[q] + 1) % DEPTH;
                mfill[q]--;
            end
            if (hit && full) movf[q] = 1;
            else if (host_wr && host_ovf_clr[q]) movf[q] = 0;
        end
    endfunction

    task automatic check_all(string tag);
        for (int q = 0; q < 2; q++) begin
            cmp(tag, "fill", q, q_fill[q], mfill[q]);
            cmp(tag, "rd_idx", q, q_rd_idx[q], mrd[q]);
            cmp(tag, "ovf", q, q_ovf[q], movf[q]);
            cmp(tag, "wm_irq R10", q, q_wm_irq[q], (mfill[q] > int'(wm_thr[q])));
            if (mfill[q] > 0) begin
                host_rd_sel = 1'(q);
                #1;
                cmp(tag, "elem R4", q, {elem_data, elem_ts, elem_fidx} == mmem[q][mrd[q]], 1);
            end
        end
    endtask

    task automatic idle();
        rx_valid = 0; rx_ok = 0; rx_sel = 0; host_wr = 0; host_iri = 0; host_ovf_clr = 0;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check_all(tag);
        idle();
    endtask

    task automatic set_rx(bit ok, bit sel);
        rx_valid = 1; rx_ok = ok; rx_sel = sel;
        rx_data = {$urandom(), $urandom()}; rx_ts = 16'($urandom()); rx_fidx = 5'($urandom());
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        idle();
        rx_data = 0; rx_ts = 0; rx_fidx = 0; host_rd_sel = 0;
        wm_thr[0] = 6'd4; wm_thr[1] = 6'd20;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // R3: rejected message changes nothing
        set_rx(0, 0); step("R3");
        // R2: fill queue 0 to full, checks R10 crossing at 5
        for (int i = 0; i < DEPTH; i++) begin set_rx(1, 0); step("R2"); end
        // R8: receive into full queue dropped, overflow raised
        set_rx(1, 0); step("R8");
        // R8: full queue with simultaneous release still drops the arrival
        set_rx(1, 0); host_wr = 1; host_iri = 2'b01; step("R8");
        // R12: clear bits without host_wr ignored
        host_ovf_clr = 2'b01; host_iri = 2'b01; step("R12");
        // R9: clear with write strobe
        host_wr = 1; host_ovf_clr = 2'b01; step("R9");
        // R6: release on empty queue 1
        host_wr = 1; host_iri = 2'b10; step("R6");
        // R7: simultaneous arrival and release on partly filled queue 0
        set_rx(1, 0); host_wr = 1; host_iri = 2'b01; step("R7");
        set_rx(1, 1); step("R2");
        set_rx(1, 1); host_wr = 1; host_iri = 2'b10; step("R7");
        // R5 and R11: drain queue 0 and keep cycling through index wrap
        for (int i = 0; i < 40; i++) begin host_wr = 1; host_iri = 2'b01; step("R5"); end
        for (int i = 0; i < 45; i++) begin
            set_rx(1, 0); host_wr = (i % 2 == 1); host_iri = 2'b01; step("R11");
        end

        // constrained random phases
        for (int ph = 0; ph < 4; ph++) begin
            for (int i = 0; i < 600; i++) begin
                int rx_w, pop_w;
                rx_w  = (ph % 2 == 0) ? 80 : 35;
                pop_w = (ph % 2 == 0) ? 30 : 75;
                if (($urandom() % 100) < rx_w) set_rx(($urandom() % 8) != 0, 1'($urandom()));
                host_wr = (($urandom() % 100) < pop_w);
                host_iri = 2'($urandom());
                host_ovf_clr = (($urandom() % 12) == 0) ? 2'($urandom()) : 2'b00;
                if (($urandom() % 50) == 0) begin
                    wm_thr[0] = 6'($urandom() % 33); wm_thr[1] = 6'($urandom() % 33);
                end
                step("R2");
            end
        end
        summary();
    end
endmodule